// File: doc/BRIEF.md
# Serial Daisy-Chain Node Identifier

This block gives every chip in a stack of cascaded repeaters its own 3-bit node number. At reset it takes the number from strap pins. A one-wire serial chain then renumbers the stack. Each chip broadcasts its own number at a fixed interval on its serial output. Each chip also listens on its serial input to the chip ahead of it, and takes that chip's number plus one as its own. This way the numbers become unique down the chain.

A broadcast frame has five symbols, each lasting a fixed number of clocks, and the line rests high between frames. The receiver locks onto the falling edge of the start symbol and samples each symbol at its centre. If a frame fails its parity check, the receiver drops it. If the input line stays high for a long stretch, this means no chip is ahead, and the node number falls back to zero. A strap-level disable input pins the number so that neither frames nor silence can change it.

The serial lines are a fixed-rate wire protocol that cannot be paused. Neither edge therefore carries a valid/ready handshake or back-pressure. Every pin is a plain level.

Top module: `chain_id_assigner`

## Requirements
- R1: While `rst_n` is low, `node_id` follows `strap_id`. The last value sampled before `rst_n` rises is held until a frame or a timeout changes it.
- R2: Between frames `ser_out` is 1. A frame is driven as five slots of `BIT_CLKS` clocks each, in this order: a 0 start slot, node bit 0, node bit 1, node bit 2, and a parity slot.
- R3: The parity slot is 1 when the frame's 3-bit number holds an even count of ones (zero or two), and 0 when the count is odd.
- R4: Frames start every `TX_INTERVAL` clocks, and the first one starts within `TX_INTERVAL` + 2 clocks of reset release. Each frame carries the value `node_id` had at its start.
- R5: When a frame on `ser_in` is well formed and passes parity, and `chain_dis_n` is 1, `node_id` becomes the received number plus one, modulo 8 (7 becomes 0).
- R6: A frame whose parity slot does not match the rule of R3 leaves `node_id` unchanged.
- R7: A start is accepted only on a 1-to-0 transition of `ser_in` that is still 0 half a slot later. A low pulse shorter than half a slot is ignored and does not block a later frame.
- R8: When `ser_in` has been 1 for `SILENCE_CLKS` consecutive clocks and `chain_dis_n` is 1, `node_id` is cleared to 0. Before that count is reached it is not cleared.
- R9: While `chain_dis_n` is 0, `node_id` keeps its value: valid frames and silence timeouts both leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the strap number |
| strap_id | input | 3 | Strapped node number |
| chain_dis_n | input | 1 | 0 freezes the node number against the chain |
| ser_in | input | 1 | Serial frames from the previous chip, resting high |
| ser_out | output | 1 | Serial frames to the next chip, resting high |
| node_id | output | 3 | Current node number |

## Verification
The assertions watch the following on every cycle:
- the node number equals the strap on the cycle reset ends;
- the number is frozen whenever the chain is disabled;
- the number becomes the received number plus one the cycle after an accepted frame;
- the number goes to zero after an expiry;
- an expiry only happens while the line is high;
- the output line falls the cycle after a broadcast begins.

Other behaviour can only be shown by the bench's scenarios, which drive frames and decode the output:
- the content and order of the slots in a transmitted frame;
- the spacing between broadcasts;
- parity rejection;
- glitch rejection at the start edge;
- the exact length of the silence window.

// File: rtl/chain_pkg.sv
package chain_pkg;
  localparam int NODE_ID_W   = 3;
  localparam int FRAME_SLOTS = NODE_ID_W + 2;

  function automatic logic even_ones_bit(input logic [NODE_ID_W-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/chain_tx.sv
module chain_tx
  import chain_pkg::*;
#(
  parameter int BIT_CLKS    = 16,
  parameter int TX_INTERVAL = 20000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NODE_ID_W-1:0] id_now,
  output logic                 ser_out
);
  localparam int IW = $clog2(TX_INTERVAL);
  localparam int BW = $clog2(BIT_CLKS);
  localparam int SW = $clog2(FRAME_SLOTS);

  logic [IW-1:0]          int_cnt;
  logic [BW-1:0]          bit_cnt;
  logic [SW-1:0]          slot;
  logic [FRAME_SLOTS-1:0] shreg;
  logic                   busy;
  logic                   go;

  assign go = (int_cnt == IW'(TX_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_cnt <= '0;
    end else if (go) begin
      int_cnt <= '0;
    end else begin
      int_cnt <= int_cnt + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_cnt <= '0;
      slot    <= '0;
      shreg   <= '1;
      ser_out <= 1'b1;
    end else if (go && !busy) begin
      busy    <= 1'b1;
      bit_cnt <= '0;
      slot    <= '0;
      shreg   <= {even_ones_bit(id_now), id_now, 1'b0};
      ser_out <= 1'b0;
    end else if (busy) begin
      if (bit_cnt == BW'(BIT_CLKS - 1)) begin
        bit_cnt <= '0;
        if (slot == SW'(FRAME_SLOTS - 1)) begin
          busy    <= 1'b0;
          ser_out <= 1'b1;
        end else begin
          slot    <= slot + SW'(1);
          ser_out <= shreg[1];
          shreg   <= {1'b1, shreg[FRAME_SLOTS-1:1]};
        end
      end else begin
        bit_cnt <= bit_cnt + BW'(1);
      end
    end
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> !ser_out);
endmodule

// File: rtl/chain_rx.sv
module chain_rx
  import chain_pkg::*;
#(
  parameter int BIT_CLKS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 din,
  output logic                 frame_ok,
  output logic [NODE_ID_W-1:0] frame_id
);
  localparam int BW   = $clog2(BIT_CLKS);
  localparam int SW   = $clog2(FRAME_SLOTS);
  localparam int HALF = BIT_CLKS / 2;

  typedef enum logic {RX_WAIT, RX_RUN} rx_state_e;

  rx_state_e            state;
  logic                 din_q;
  logic [BW-1:0]        cnt;
  logic [SW-1:0]        slot;
  logic [NODE_ID_W-1:0] data;
  logic                 sample;

  assign sample = (slot == '0) ? (cnt == BW'(HALF - 1)) : (cnt == BW'(BIT_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_WAIT;
      din_q    <= 1'b1;
      cnt      <= '0;
      slot     <= '0;
      data     <= '0;
      frame_ok <= 1'b0;
      frame_id <= '0;
    end else begin
      din_q    <= din;
      frame_ok <= 1'b0;
      case (state)
        RX_WAIT: begin
          if (din_q && !din) begin
            state <= RX_RUN;
            cnt   <= '0;
            slot  <= '0;
          end
        end
        RX_RUN: begin
          if (!sample) begin
            cnt <= cnt + BW'(1);
          end else begin
            cnt <= '0;
            if (slot == '0) begin
              if (din) state <= RX_WAIT;
              else     slot  <= slot + SW'(1);
            end else if (slot == SW'(FRAME_SLOTS - 1)) begin
              state <= RX_WAIT;
              if (din == even_ones_bit(data)) begin
                frame_ok <= 1'b1;
                frame_id <= data;
              end
            end else begin
              data <= {din, data[NODE_ID_W-1:1]};
              slot <= slot + SW'(1);
            end
          end
        end
        default: state <= RX_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/chain_silence.sv
module chain_silence #(
  parameter int SILENCE_CLKS = 400000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic expire
);
  localparam int CW = $clog2(SILENCE_CLKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (!din) begin
        cnt <= '0;
      end else if (cnt != CW'(SILENCE_CLKS)) begin
        cnt <= cnt + CW'(1);
        if (cnt == CW'(SILENCE_CLKS - 1)) expire <= 1'b1;
      end
    end
  end

  assert_expire_on_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(din));
endmodule

// File: rtl/chain_id_assigner.sv
module chain_id_assigner
  import chain_pkg::*;
#(
  parameter int BIT_CLKS     = 16,
  parameter int TX_INTERVAL  = 20000,
  parameter int SILENCE_CLKS = 400000000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NODE_ID_W-1:0] strap_id,
  input  logic                 chain_dis_n,
  input  logic                 ser_in,
  output logic                 ser_out,
  output logic [NODE_ID_W-1:0] node_id
);
  logic [1:0]           sync_q;
  logic                 din;
  logic                 rx_ok;
  logic [NODE_ID_W-1:0] rx_id;
  logic                 expire;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], ser_in};
  end
  assign din = sync_q[1];

  chain_tx #(.BIT_CLKS(BIT_CLKS), .TX_INTERVAL(TX_INTERVAL)) u_tx (
    .clk(clk), .rst_n(rst_n), .id_now(node_id), .ser_out(ser_out));

  chain_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
    .clk(clk), .rst_n(rst_n), .din(din), .frame_ok(rx_ok), .frame_id(rx_id));

  chain_silence #(.SILENCE_CLKS(SILENCE_CLKS)) u_sil (
    .clk(clk), .rst_n(rst_n), .din(din), .expire(expire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_id <= strap_id;
    end else if (chain_dis_n) begin
      if (rx_ok)       node_id <= rx_id + NODE_ID_W'(1);
      else if (expire) node_id <= '0;
    end
  end

  assert_strap_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> node_id == $past(strap_id));
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_dis_n |=> $stable(node_id));
  assert_plus_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_dis_n && rx_ok) |=> node_id == NODE_ID_W'($past(rx_id) + NODE_ID_W'(1)));
  assert_timeout_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_dis_n && expire && !rx_ok) |=> node_id == '0);
endmodule

// File: tb/tb_chain_id_assigner.sv
`timescale 1ns/1ps
module tb_chain_id_assigner;
  localparam int BIT   = 8;
  localparam int INTV  = 400;
  localparam int SIL   = 3000;
  localparam int HALFB = BIT / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_id = 3'd5;
  logic       chain_dis_n = 1'b1;
  logic       ser_in = 1'b1;
  logic       ser_out;
  logic [2:0] node_id;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chain_id_assigner #(.BIT_CLKS(BIT), .TX_INTERVAL(INTV), .SILENCE_CLKS(SIL)) dut (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .chain_dis_n(chain_dis_n),
    .ser_in(ser_in), .ser_out(ser_out), .node_id(node_id));

  function automatic logic [2:0] exp_next(input logic [2:0] v);
    return v + 3'd1;
  endfunction

  function automatic logic exp_par(input logic [2:0] v);
    return ($countones(v) % 2) == 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] v, input bit good);
    logic [4:0] slots;
    slots = {good ? exp_par(v) : ~exp_par(v), v[2], v[1], v[0], 1'b0};
    for (int i = 0; i < 5; i++) begin
      ser_in = slots[i];
      wait_cyc(BIT);
    end
    ser_in = 1'b1;
    wait_cyc(BIT);
  endtask

  task automatic grab_frame(output logic [2:0] v, output logic p, output int start);
    @(negedge clk);
    while (ser_out) @(negedge clk);
    start = cyc;
    wait_cyc(HALFB);
    for (int i = 0; i < 3; i++) begin
      wait_cyc(BIT);
      v[i] = ser_out;
    end
    wait_cyc(BIT);
    p = ser_out;
    wait_cyc(BIT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [2:0] v, prev, rid;
    logic p;
    int s0, s1, rel;
    void'($urandom(32'd20240611));
    wait_cyc(4);
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    check("R1 strap load", node_id, 5);
    check("R2 idle high", ser_out, 1);

    grab_frame(v, p, s0);
    check("R2 frame id", v, 5);
    check("R3 parity", p, exp_par(3'd5));
    check("R4 first start bound", (s0 - rel <= INTV + 2), 1);
    grab_frame(v, p, s1);
    check("R4 interval", s1 - s0, INTV);

    send_frame(3'd7, 1'b1);
    check("R5 wrap 7 to 0", node_id, 0);
    grab_frame(v, p, s0);
    check("R4 carries current id", v, 0);
    check("R3 parity of zero", p, 1);

    for (int k = 0; k < 10; k++) begin
      rid = 3'($urandom_range(0, 7));
      send_frame(rid, 1'b1);
      check("R5 random frame", node_id, exp_next(rid));
      wait_cyc($urandom_range(0, 20));
    end

    prev = node_id;
    for (int k = 0; k < 3; k++) begin
      rid = 3'($urandom_range(0, 7));
      send_frame(rid, 1'b0);
      check("R6 bad parity dropped", node_id, prev);
    end

    ser_in = 1'b0;
    wait_cyc(2);
    ser_in = 1'b1;
    wait_cyc(3 * BIT);
    check("R7 glitch ignored", node_id, prev);
    send_frame(3'd3, 1'b1);
    check("R7 frame after glitch", node_id, 4);

    chain_dis_n = 1'b0;
    wait_cyc(2);
    send_frame(3'd1, 1'b1);
    check("R9 frame ignored when disabled", node_id, 4);
    wait_cyc(SIL + 100);
    check("R9 silence ignored when disabled", node_id, 4);
    chain_dis_n = 1'b1;
    wait_cyc(2);

    send_frame(3'd5, 1'b1);
    check("R8 setup", node_id, 6);
    wait_cyc(SIL - 60 - BIT);
    check("R8 not cleared early", node_id, 6);
    wait_cyc(100);
    check("R8 cleared after silence", node_id, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule